// File: doc/BRIEF.md
# Bit-Plane Weighted LED Scan Driver

This block turns grey-scale pixel data, held in video memory as separate bit planes, into the serial stream and timing that a chain of shift-register LED drivers expects. For one panel row and one bit plane it reads the red, green and blue plane words from memory. It shifts the three colour bits of each column out in parallel on a common serial clock and then pulses a latch so the drivers take the new row pattern.

Grey levels come from time weighting rather than from a per-pixel comparator. After each latch the output enable stays on for a span proportional to the binary weight of the plane just latched: plane k lasts `BASE_TICKS * 2^k` clock cycles. With eight planes, a pixel's total on-time over a row is its 8-bit value times the base time. While one plane is lit, the block fetches and shifts the following plane. The latch waits until the lit plane's span has run out. After the top plane of a row, the scan moves to the next row and begins again at plane 0. After the last row it returns to row 0.

Memory is a simple read port. The block drives an address and a read strobe, and the word appears on `mem_rdata` one cycle later. Each memory word carries `DATA_W` neighbouring columns of one plane of one colour. `COLS` must be a multiple of `DATA_W`.

Top module: `led_plane_scan`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `led_oe`, `row_latch`, `scan_clk` and `mem_rd` are all 0.
- R2: For row r, plane p and column group g (g = column / DATA_W), the block reads address `BASE + (r*PLANES + p)*GROUPS + g`. Here BASE is `R_BASE`, `G_BASE` or `B_BASE`. Each group is read red first, then green, then blue. That gives exactly 3*GROUPS read strobes per latched plane. A word read in one cycle is taken from `mem_rdata` in the next cycle.
- R3: Between two latch pulses there are exactly `COLS` rising edges of `scan_clk`. On edge number c (counted from 0), `sd_r`, `sd_g` and `sd_b` carry bit c mod DATA_W of the word for group c / DATA_W of their own colour.
- R4: `scan_clk` is high for exactly one cycle per pulse. The serial data is set in the cycle before the pulse and holds its value while the clock is high.
- R5: `row_latch` is a single-cycle pulse. It is high only while `led_oe` is 0 and `scan_clk` is 0.
- R6: `led_oe` rises in the cycle after a latch pulse. It stays high for exactly `BASE_TICKS * 2^p` cycles, where p is the plane that was just latched.
- R7: Planes are latched in order 0 to PLANES-1 within a row. Rows then advance by one and wrap from ROWS-1 back to 0.
- R8: Fetching and shifting of the next plane start right after a latch. They run while `led_oe` is high. The following latch waits for `led_oe` to fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Video memory read address |
| mem_rd | output | 1 | Read strobe; data is due one cycle later |
| mem_rdata | input | DATA_W | Read data, DATA_W columns of one plane of one colour |
| scan_clk | output | 1 | Serial shift clock to the panel drivers |
| sd_r | output | 1 | Red serial data |
| sd_g | output | 1 | Green serial data |
| sd_b | output | 1 | Blue serial data |
| row_latch | output | 1 | Latch pulse that transfers the shifted row into the drivers |
| led_oe | output | 1 | Output enable, high while the latched plane is lit |

## Verification
The bench builds the block with COLS=24, DATA_W=8, ROWS=3, PLANES=8 and BASE_TICKS=3, so each row has three column groups. A full frame is short enough to run past the row wrap and then through a second, directed run after a reset in mid-operation. With three groups, the reads go through a middle group whose address is neither the first nor the last. The odd base time makes any error in the weighted on-time visible for every plane. Short low planes cover the case where shifting outlasts the lit span. Long high planes cover the case where shifting finishes while the panel is still lit.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  localparam int unsigned N_COLOURS = 3;

  typedef enum logic [1:0] {
    CTL_KICK  = 2'd0,
    CTL_SHIFT = 2'd1,
    CTL_HOLD  = 2'd2,
    CTL_LATCH = 2'd3
  } ctl_state_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_LOW   = 2'd2,
    ENG_HIGH  = 2'd3
  } eng_state_t;

endpackage

// File: rtl/scan_position.sv
module scan_position #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned PLANES = 8,
  parameter int unsigned ROW_W  = 2,
  parameter int unsigned PL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row_o,
  output logic [PL_W-1:0]  plane_o
);

  logic [ROW_W-1:0] row_q, row_d;
  logic [PL_W-1:0]  plane_q, plane_d;
  logic             last_plane, last_row;

  assign last_plane = (plane_q == PL_W'(PLANES - 1));
  assign last_row   = (row_q == ROW_W'(ROWS - 1));

  always_comb begin
    row_d   = row_q;
    plane_d = plane_q;
    if (last_plane) begin
      plane_d = '0;
      row_d   = last_row ? '0 : row_q + 1'b1;
    end else begin
      plane_d = plane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      plane_q <= '0;
    end else if (advance) begin
      row_q   <= row_d;
      plane_q <= plane_d;
    end
  end

  assign row_o   = row_q;
  assign plane_o = plane_q;

endmodule

// File: rtl/weight_timer.sv
module weight_timer #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned PLANES     = 8,
  parameter int unsigned PL_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PL_W-1:0] plane_i,
  output logic            busy_o
);

  localparam int unsigned MAX_SPAN = BASE_TICKS * (2 ** (PLANES - 1));
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = (CNT_W'(BASE_TICKS) << plane_i) - CNT_W'(1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/plane_fetch_shift.sv
module plane_fetch_shift
  import led_scan_pkg::*;
#(
  parameter int unsigned COLS   = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PLANES = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned R_BASE = 0,
  parameter int unsigned G_BASE = 1024,
  parameter int unsigned B_BASE = 2048,
  parameter int unsigned ROW_W  = 2,
  parameter int unsigned PL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [PL_W-1:0]      plane_i,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 sclk_o,
  output logic [N_COLOURS-1:0] sdata_o,
  output logic                 done_o
);

  localparam int unsigned GROUPS = COLS / DATA_W;
  localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  eng_state_t        state_q, state_d;
  logic [1:0]        fidx_q, fidx_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;
  logic              last_bit, last_grp;
  logic [ADDR_W-1:0] base_sel, rel_addr;

  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
  assign last_grp = (grp_q == GRP_W'(GROUPS - 1));

  // next-state logic of the fetch / shift engine
  always_comb begin
    state_d = state_q;
    fidx_d  = fidx_q;
    grp_d   = grp_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_FETCH;
          fidx_d  = '0;
          grp_d   = '0;
        end
      end
      ENG_FETCH: begin
        fidx_d = fidx_q + 1'b1;
        if (fidx_q == 2'd3) begin
          state_d = ENG_LOW;
          bit_d   = '0;
        end
      end
      ENG_LOW: begin
        state_d = ENG_HIGH;
      end
      ENG_HIGH: begin
        if (last_bit) begin
          if (last_grp) begin
            state_d = ENG_IDLE;
            done_d  = 1'b1;
          end else begin
            grp_d   = grp_q + 1'b1;
            fidx_d  = '0;
            state_d = ENG_FETCH;
          end
        end else begin
          bit_d   = bit_q + 1'b1;
          state_d = ENG_LOW;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      fidx_q  <= '0;
      grp_q   <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fidx_q  <= fidx_d;
      grp_q   <= grp_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  // address: colour base plus the plane-relative word offset
  always_comb begin
    unique case (fidx_q)
      2'd0:    base_sel = ADDR_W'(R_BASE);
      2'd1:    base_sel = ADDR_W'(G_BASE);
      default: base_sel = ADDR_W'(B_BASE);
    endcase
    rel_addr = ((ADDR_W'(row_i) * ADDR_W'(PLANES)) + ADDR_W'(plane_i))
               * ADDR_W'(GROUPS) + ADDR_W'(grp_q);
  end

  assign mem_addr = base_sel + rel_addr;
  assign mem_rd   = (state_q == ENG_FETCH) && (fidx_q != 2'd3);
  assign sclk_o   = (state_q == ENG_HIGH);
  assign done_o   = done_q;

  // one lane per colour: capture the word one cycle after its read, then shift LSB first
  for (genvar c = 0; c < N_COLOURS; c++) begin : g_lane
    logic [DATA_W-1:0] word_q, word_d;
    logic              take, step, lane_en;

    assign take    = (state_q == ENG_FETCH) && (fidx_q == 2'(c + 1));
    assign step    = (state_q == ENG_HIGH) && !last_bit;
    assign lane_en = take | step;

    always_comb begin
      word_d = word_q;
      if (take) begin
        word_d = mem_rdata;
      end else if (step) begin
        word_d = word_q >> 1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (lane_en) begin
        word_q <= word_d;
      end
    end

    assign sdata_o[c] = word_q[0];
  end

endmodule

// File: rtl/led_plane_scan.sv
module led_plane_scan
  import led_scan_pkg::*;
#(
  parameter int unsigned COLS       = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ROWS       = 4,
  parameter int unsigned PLANES     = 8,
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned R_BASE     = 0,
  parameter int unsigned G_BASE     = 1024,
  parameter int unsigned B_BASE     = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              scan_clk,
  output logic              sd_r,
  output logic              sd_g,
  output logic              sd_b,
  output logic              row_latch,
  output logic              led_oe
);

  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned PL_W  = (PLANES > 1) ? $clog2(PLANES) : 1;

  ctl_state_t           ctl_q, ctl_d;
  logic                 eng_start, eng_done, timer_start, timer_busy, advance;
  logic [ROW_W-1:0]     cur_row;
  logic [PL_W-1:0]      cur_plane;
  logic [N_COLOURS-1:0] sdata;

  // sequencing: shift, wait for the lit plane to expire, latch, light
  always_comb begin
    ctl_d       = ctl_q;
    eng_start   = 1'b0;
    timer_start = 1'b0;
    advance     = 1'b0;
    unique case (ctl_q)
      CTL_KICK: begin
        eng_start = 1'b1;
        ctl_d     = CTL_SHIFT;
      end
      CTL_SHIFT: begin
        if (eng_done) ctl_d = CTL_HOLD;
      end
      CTL_HOLD: begin
        if (!timer_busy) ctl_d = CTL_LATCH;
      end
      CTL_LATCH: begin
        timer_start = 1'b1;
        advance     = 1'b1;
        ctl_d       = CTL_KICK;
      end
      default: ctl_d = CTL_KICK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_KICK;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  scan_position #(
    .ROWS  (ROWS),
    .PLANES(PLANES),
    .ROW_W (ROW_W),
    .PL_W  (PL_W)
  ) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(advance),
    .row_o  (cur_row),
    .plane_o(cur_plane)
  );

  plane_fetch_shift #(
    .COLS  (COLS),
    .DATA_W(DATA_W),
    .PLANES(PLANES),
    .ADDR_W(ADDR_W),
    .R_BASE(R_BASE),
    .G_BASE(G_BASE),
    .B_BASE(B_BASE),
    .ROW_W (ROW_W),
    .PL_W  (PL_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .row_i    (cur_row),
    .plane_i  (cur_plane),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_rdata(mem_rdata),
    .sclk_o   (scan_clk),
    .sdata_o  (sdata),
    .done_o   (eng_done)
  );

  weight_timer #(
    .BASE_TICKS(BASE_TICKS),
    .PLANES    (PLANES),
    .PL_W      (PL_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (timer_start),
    .plane_i(cur_plane),
    .busy_o (timer_busy)
  );

  assign sd_r      = sdata[0];
  assign sd_g      = sdata[1];
  assign sd_b      = sdata[2];
  assign row_latch = (ctl_q == CTL_LATCH);
  assign led_oe    = timer_busy;

endmodule

// File: rtl/led_plane_scan_chk.sv
module led_plane_scan_chk #(
  parameter int unsigned COLS   = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ROWS   = 4,
  parameter int unsigned PLANES = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned R_BASE = 0,
  parameter int unsigned G_BASE = 1024,
  parameter int unsigned B_BASE = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              scan_clk,
  input logic              sd_r,
  input logic              sd_g,
  input logic              sd_b,
  input logic              row_latch,
  input logic              led_oe
);

  localparam int unsigned SPAN = ROWS * PLANES * (COLS / DATA_W);

  logic addr_ok;
  always_comb begin
    addr_ok = ((32'(mem_addr) >= R_BASE) && (32'(mem_addr) < R_BASE + SPAN)) ||
              ((32'(mem_addr) >= G_BASE) && (32'(mem_addr) < G_BASE + SPAN)) ||
              ((32'(mem_addr) >= B_BASE) && (32'(mem_addr) < B_BASE + SPAN));
  end

  assert_read_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> addr_ok);

  assert_sclk_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clk |=> !scan_clk);

  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_clk) |-> $stable({sd_r, sd_g, sd_b}));

  assert_latch_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> !row_latch);

  assert_latch_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |-> (!led_oe && !scan_clk));

  assert_lit_after_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> led_oe);

  assert_no_latch_while_lit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_oe |-> !row_latch);

endmodule

bind led_plane_scan led_plane_scan_chk #(
  .COLS  (COLS),
  .DATA_W(DATA_W),
  .ROWS  (ROWS),
  .PLANES(PLANES),
  .ADDR_W(ADDR_W),
  .R_BASE(R_BASE),
  .G_BASE(G_BASE),
  .B_BASE(B_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .scan_clk (scan_clk),
  .sd_r     (sd_r),
  .sd_g     (sd_g),
  .sd_b     (sd_b),
  .row_latch(row_latch),
  .led_oe   (led_oe)
);

// File: tb/led_plane_scan_tb.sv
module led_plane_scan_tb;

  localparam int CLK_PERIOD = 10;
  localparam int COLS       = 24;
  localparam int DATA_W     = 8;
  localparam int ROWS       = 3;
  localparam int PLANES     = 8;
  localparam int BASE_TICKS = 3;
  localparam int ADDR_W     = 10;
  localparam int R_BASE     = 0;
  localparam int G_BASE     = 256;
  localparam int B_BASE     = 512;
  localparam int GROUPS     = COLS / DATA_W;
  localparam int MEM_WORDS  = 1024;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd;
  logic [DATA_W-1:0] mem_rdata;
  logic              scan_clk, sd_r, sd_g, sd_b, row_latch, led_oe;

  logic [DATA_W-1:0] mem [MEM_WORDS];

  int  checks;
  int  errors;
  bit  finished;

  led_plane_scan #(
    .COLS(COLS), .DATA_W(DATA_W), .ROWS(ROWS), .PLANES(PLANES),
    .BASE_TICKS(BASE_TICKS), .ADDR_W(ADDR_W),
    .R_BASE(R_BASE), .G_BASE(G_BASE), .B_BASE(B_BASE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .scan_clk(scan_clk), .sd_r(sd_r), .sd_g(sd_g),
    .sd_b(sd_b), .row_latch(row_latch), .led_oe(led_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[int'(mem_addr)];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int colour, input int row,
                                   input int plane, input int col);
    int base;
    int addr;
    base = (colour == 0) ? R_BASE : (colour == 1) ? G_BASE : B_BASE;
    addr = base + (row * PLANES + plane) * GROUPS + col / DATA_W;
    return mem[addr][col % DATA_W];
  endfunction

  function automatic logic [COLS-1:0] exp_vec(input int colour, input int row,
                                              input int plane);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[c] = exp_bit(colour, row, plane, c);
    return v;
  endfunction

  // monitor state
  int              nbits, nreads, exp_row, exp_plane, lit_plane, oe_run, latches;
  bit              prev_sclk, prev_oe, prev_latch, overlap_seen, after_reset;
  logic [COLS-1:0] got_r, got_g, got_b;

  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0; nreads = 0; exp_row = 0; exp_plane = 0; lit_plane = 0;
      oe_run = 0; latches = 0; prev_sclk = 0; prev_oe = 0; prev_latch = 0;
      after_reset = 1; got_r = '0; got_g = '0; got_b = '0;
    end else begin
      if (after_reset) begin
        check(!led_oe && !row_latch && !scan_clk && !mem_rd, "R1",
              "outputs first cycle after reset",
              {led_oe, row_latch, scan_clk, mem_rd}, 0);
        after_reset = 0;
      end
      if (prev_latch) check(led_oe, "R6", "oe one cycle after latch", led_oe, 1);
      if (mem_rd) nreads++;
      if (scan_clk && prev_sclk) check(0, "R4", "scan_clk wider than one cycle", 2, 1);
      if (scan_clk && !prev_sclk) begin
        if (nbits < COLS) begin
          got_r[nbits] = sd_r; got_g[nbits] = sd_g; got_b[nbits] = sd_b;
        end
        nbits++;
        if (led_oe) overlap_seen = 1;
      end
      if (led_oe) oe_run++;
      else if (prev_oe) begin
        check(oe_run == (BASE_TICKS << lit_plane), "R6", "oe width",
              oe_run, BASE_TICKS << lit_plane);
        oe_run = 0;
      end
      if (row_latch) begin
        string tag;
        tag = (latches >= ROWS * PLANES) ? "R7" : "R3";
        check(!led_oe && !scan_clk, "R5", "latch while lit or clocking",
              {led_oe, scan_clk}, 0);
        check(nbits == COLS, "R3", "clock edges per latch", nbits, COLS);
        check(nreads == 3 * GROUPS, "R2", "reads per plane", nreads, 3 * GROUPS);
        check(got_r == exp_vec(0, exp_row, exp_plane), tag, "red row bits",
              longint'(got_r), longint'(exp_vec(0, exp_row, exp_plane)));
        check(got_g == exp_vec(1, exp_row, exp_plane), tag, "green row bits",
              longint'(got_g), longint'(exp_vec(1, exp_row, exp_plane)));
        check(got_b == exp_vec(2, exp_row, exp_plane), "R2", "blue row bits",
              longint'(got_b), longint'(exp_vec(2, exp_row, exp_plane)));
        lit_plane = exp_plane;
        if (exp_plane == PLANES - 1) begin
          exp_plane = 0;
          exp_row   = (exp_row == ROWS - 1) ? 0 : exp_row + 1;
        end else begin
          exp_plane++;
        end
        nbits = 0; nreads = 0; latches++;
      end
      prev_sclk = scan_clk; prev_oe = led_oe; prev_latch = row_latch;
    end
  end

  task automatic fill_random();
    for (int a = 0; a < MEM_WORDS; a++) begin
      int unsigned r;
      r = $urandom;
      case (r % 4)
        0:       mem[a] = '0;
        1:       mem[a] = '1;
        default: mem[a] = DATA_W'($urandom_range(255, 0));
      endcase
    end
  endtask

  task automatic fill_directed();
    for (int a = 0; a < MEM_WORDS; a++) begin
      if (a >= B_BASE)      mem[a] = (a % 2 == 0) ? 8'hA5 : 8'h5A;
      else if (a >= G_BASE) mem[a] = 8'h00;
      else                  mem[a] = 8'hFF;
    end
  endtask

  task automatic wait_latches(input int n);
    while (latches < n && !finished) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    checks = 0; errors = 0; finished = 0; overlap_seen = 0;
    rst_n = 1'b0;
    mem_rdata = '0;
    fill_random();
    repeat (3) begin
      @(negedge clk);
      check(!led_oe && !row_latch && !scan_clk && !mem_rd, "R1",
            "outputs in reset", {led_oe, row_latch, scan_clk, mem_rd}, 0);
    end
    rst_n = 1'b1;
    // random data, run past the row wrap (R7)
    wait_latches(ROWS * PLANES + 6);
    check(overlap_seen, "R8", "shifting during lit span", overlap_seen, 1);
    // reset mid-operation, then directed patterns
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!led_oe && !row_latch && !scan_clk && !mem_rd, "R1",
          "outputs after mid-run reset", {led_oe, row_latch, scan_clk, mem_rd}, 0);
    fill_directed();
    @(negedge clk);
    rst_n = 1'b1;
    wait_latches(PLANES + 2);
    report();
  end

endmodule